// File: doc/BRIEF.md
# Message-Based Servant Register Set

This block is the bus-facing register front end of a message-based servant on a 16-bit backplane. A bus master reaches it through a slave port that carries a word offset, separate read and write strobes and 16-bit data. The block holds three bus registers: status/control, response and data-low. Read data comes back from a registered output.

The local processor uses a 4-bit control word and a data-load port. With the control word it raises the handshake flags: write-ready, read-ready and the error indication. Bus traffic on the data-low register then lowers the two ready flags. A bus read of the data-low word clears read-ready. A bus write of that word clears write-ready.

The status/control register drives two outputs to the rest of the module, a soft-reset level and a fail-inhibit level. The block also reports self-test pass, initialisation-ready and an inverted module-select level. It produces a fail output, which is raised when self-test has failed and fail-inhibit is not set.

Top module: `msg_servant_regs`

## Requirements
- R1: A read at word offset 5 (response) returns bit 15 = 0, bit 14 = 1, bits 13:12 = 0 and bits 8:0 = all ones. Bit 11 is the error flag, active low (1 = no error). Bit 10 is read-ready and bit 9 is write-ready.
- R2: Read-ready is set only by a local control write whose bit 1 is 1. It is cleared by a bus read of word offset 7 (data-low).
- R3: Write-ready is set only by a local control write whose bit 0 is 1. It is cleared by a bus write of word offset 7.
- R4: The error flag is changed only by the local control word. Bit 2 = 1 sets it and bit 3 = 1 clears it. When both bits are 1 in one write, the flag is set.
- R5: A flag set by a local control write in the same cycle as a bus data-low access that would clear it stays set.
- R6: A read at word offset 2 (status/control) returns bit 15 = 0 and bit 14 = the inverse of mod_sel. Bits 13:4 read as 0. Bit 3 is init_ready, bit 2 is selftest_pass, bit 1 is fail-inhibit and bit 0 is soft reset.
- R7: A bus write at word offset 2 loads soft reset from data bit 0, where 1 enters soft reset and 0 leaves it. soft_rst follows from the clock edge that takes the write. Data bits 15:2 are ignored.
- R8: The same write loads fail-inhibit from data bit 1. fail_out is 1 exactly when selftest_pass was 0 and fail-inhibit was 0 at the previous clock edge.
- R9: A bus write at offset 7 stores 16 bits into data-low. A local data load also stores into data-low. When both happen in the same cycle, the bus write wins. A bus read at offset 7 returns the stored word.
- R10: A hard reset clears soft reset, fail-inhibit, read-ready, write-ready and the error flag. It also clears the read data and fail_out.
- R11: bus_rdata is loaded at the clock edge that samples bus_rd. A read at any other offset returns 0. A bus write at any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| bus_addr | input | ADDR_W | Bus word offset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered bus read data |
| loc_ctl_wr | input | 1 | Local control word write strobe |
| loc_ctl | input | 4 | Local control word: bit0 set write-ready, bit1 set read-ready, bit2 set error, bit3 clear error |
| loc_dat_wr | input | 1 | Local data-low load strobe |
| loc_dat | input | 16 | Local data-low load value |
| dlow_out | output | 16 | Current data-low contents |
| mod_sel | input | 1 | Module-select level, active high |
| init_ready | input | 1 | Initialisation complete |
| selftest_pass | input | 1 | Self-test passed |
| soft_rst | output | 1 | Soft reset level |
| fail_inhibit | output | 1 | Fail-inhibit level |
| fail_out | output | 1 | Fail request toward the backplane |

## Verification
Most results are due one clock edge after the stimulus. A bus read presents its word one edge after the strobe, and a flag or register write shows in the next read. soft_rst and fail_inhibit change at the edge that takes the write. A change on selftest_pass reaches fail_out one edge later. A write to fail-inhibit reaches fail_out two edges after its strobe, because fail_out is registered from the stored inhibit bit. The bench drives each strobe for one cycle from a falling edge. It samples at the next falling edge, and waits one more cycle for the two-edge fail_out path.

// File: rtl/msv_pkg.sv
package msv_pkg;
  localparam int DW          = 16;
  localparam int CTL_W       = 4;
  localparam int OFS_STATCTL = 2;
  localparam int OFS_RESP    = 5;
  localparam int OFS_DLOW    = 7;
  localparam int CTL_SET_WRDY = 0;
  localparam int CTL_SET_RRDY = 1;
  localparam int CTL_SET_ERR  = 2;
  localparam int CTL_CLR_ERR  = 3;

  typedef struct packed {
    logic err;
    logic rrdy;
    logic wrdy;
  } hs_flags_t;
endpackage

// File: rtl/msv_setclr_flag.sv
module msv_setclr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/msv_hs_flags.sv
module msv_hs_flags
  import msv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl,
  input  logic             dat_rd,
  input  logic             dat_wr,
  output hs_flags_t        flags
);
  localparam int NFLAG = 3;
  logic [NFLAG-1:0] set_v, clr_v, q_v;

  always_comb begin
    set_v[0] = ctl_wr & ctl[CTL_SET_WRDY];
    clr_v[0] = dat_wr;
    set_v[1] = ctl_wr & ctl[CTL_SET_RRDY];
    clr_v[1] = dat_rd;
    set_v[2] = ctl_wr & ctl[CTL_SET_ERR];
    clr_v[2] = ctl_wr & ctl[CTL_CLR_ERR];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    msv_setclr_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_v[i]),
      .clr_i(clr_v[i]),
      .q    (q_v[i])
    );
  end

  assign flags.wrdy = q_v[0];
  assign flags.rrdy = q_v[1];
  assign flags.err  = q_v[2];

  // R2
  rrdy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && !(ctl_wr && ctl[CTL_SET_RRDY])) |=> !flags.rrdy);
  // R3
  wrdy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !(ctl_wr && ctl[CTL_SET_WRDY])) |=> !flags.wrdy);
  // R5
  wrdy_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl[CTL_SET_WRDY]) |=> flags.wrdy);
  // R4
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.err) |-> $past(ctl_wr && ctl[CTL_SET_ERR]));
endmodule

// File: rtl/msv_statctl.sv
module msv_statctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wbits,
  input  logic       pass_in,
  output logic       soft_rst,
  output logic       inhibit,
  output logic       fail_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst <= 1'b0;
      inhibit  <= 1'b0;
      fail_out <= 1'b0;
    end else begin
      if (wr_en) begin
        soft_rst <= wbits[0];
        inhibit  <= wbits[1];
      end
      fail_out <= ~pass_in & ~inhibit;
    end
  end

  // R8
  fail_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    fail_out |-> !$past(inhibit));
  // R7
  srst_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (soft_rst == $past(wbits[0])));
endmodule

// File: rtl/msv_readback.sv
module msv_readback
  import msv_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  hs_flags_t         flags,
  input  logic              mod_sel,
  input  logic              init_ready,
  input  logic              pass_in,
  input  logic              inhibit,
  input  logic              soft_rst,
  input  logic [DW-1:0]     dlow,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] stat_word, resp_word, sel_word;

  always_comb begin
    stat_word = {1'b0, ~mod_sel, 10'b0, init_ready, pass_in, inhibit, soft_rst};
    resp_word = {1'b0, 1'b1, 2'b00, ~flags.err, flags.rrdy, flags.wrdy, 9'h1FF};
    if (addr == ADDR_W'(OFS_STATCTL))   sel_word = stat_word;
    else if (addr == ADDR_W'(OFS_RESP)) sel_word = resp_word;
    else if (addr == ADDR_W'(OFS_DLOW)) sel_word = dlow;
    else                                sel_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_word;
  end
endmodule

// File: rtl/msg_servant_regs.sv
module msg_servant_regs
  import msv_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              loc_ctl_wr,
  input  logic [CTL_W-1:0]  loc_ctl,
  input  logic              loc_dat_wr,
  input  logic [DW-1:0]     loc_dat,
  output logic [DW-1:0]     dlow_out,
  input  logic              mod_sel,
  input  logic              init_ready,
  input  logic              selftest_pass,
  output logic              soft_rst,
  output logic              fail_inhibit,
  output logic              fail_out
);
  logic hit_stat, hit_resp, hit_dlow;
  logic dat_rd, dat_wr, stat_wr;
  hs_flags_t flags;
  logic [DW-1:0] dlow_q;

  assign hit_stat = (bus_addr == ADDR_W'(OFS_STATCTL));
  assign hit_resp = (bus_addr == ADDR_W'(OFS_RESP));
  assign hit_dlow = (bus_addr == ADDR_W'(OFS_DLOW));
  assign dat_rd   = bus_rd & hit_dlow;
  assign dat_wr   = bus_wr & hit_dlow;
  assign stat_wr  = bus_wr & hit_stat;

  // R9: bus write has priority over the local load
  always_ff @(posedge clk) begin
    if (rst)             dlow_q <= '0;
    else if (dat_wr)     dlow_q <= bus_wdata;
    else if (loc_dat_wr) dlow_q <= loc_dat;
  end
  assign dlow_out = dlow_q;

  msv_hs_flags u_flags (
    .clk   (clk),
    .rst   (rst),
    .ctl_wr(loc_ctl_wr),
    .ctl   (loc_ctl),
    .dat_rd(dat_rd),
    .dat_wr(dat_wr),
    .flags (flags)
  );

  msv_statctl u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (stat_wr),
    .wbits   (bus_wdata[1:0]),
    .pass_in (selftest_pass),
    .soft_rst(soft_rst),
    .inhibit (fail_inhibit),
    .fail_out(fail_out)
  );

  msv_readback #(.ADDR_W(ADDR_W)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .flags     (flags),
    .mod_sel   (mod_sel),
    .init_ready(init_ready),
    .pass_in   (selftest_pass),
    .inhibit   (fail_inhibit),
    .soft_rst  (soft_rst),
    .dlow      (dlow_q),
    .rdata     (bus_rdata)
  );

  // R1
  resp_const_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_resp) |=> (bus_rdata[15:12] == 4'b0100 && bus_rdata[8:0] == 9'h1FF));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit_stat && !hit_resp && !hit_dlow) |=> (bus_rdata == '0));
  // R9
  dlow_bus_chk: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> (dlow_out == $past(bus_wdata)));
endmodule

// File: tb/sim_msg_servant_regs.sv
module sim_msg_servant_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic loc_ctl_wr = 0;
  logic [3:0] loc_ctl = '0;
  logic loc_dat_wr = 0;
  logic [15:0] loc_dat = '0;
  logic [15:0] dlow_out;
  logic mod_sel = 0, init_ready = 1, selftest_pass = 1;
  logic soft_rst, fail_inhibit, fail_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msg_servant_regs #(.ADDR_W(5)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .loc_ctl_wr(loc_ctl_wr),
    .loc_ctl(loc_ctl), .loc_dat_wr(loc_dat_wr), .loc_dat(loc_dat),
    .dlow_out(dlow_out), .mod_sel(mod_sel), .init_ready(init_ready),
    .selftest_pass(selftest_pass), .soft_rst(soft_rst),
    .fail_inhibit(fail_inhibit), .fail_out(fail_out)
  );

  // {req, kind, addr, data, expected}; kind 0 read+check, 1 bus write,
  // 2 local control word, 3 local data load
  localparam int NV = 26;
  localparam logic [55:0] VEC [NV] = '{
    56'h01_00_05_0000_49FF, // R1 response after reset
    56'h03_02_00_0001_0000, // R3 set write-ready
    56'h03_00_05_0000_4BFF, // R3
    56'h03_01_07_1234_0000, // R3 bus write data-low
    56'h03_00_05_0000_49FF, // R3 write-ready cleared
    56'h09_00_07_0000_1234, // R9
    56'h02_02_00_0002_0000, // R2 set read-ready
    56'h02_00_05_0000_4DFF, // R2
    56'h02_00_07_0000_1234, // R2 data read clears
    56'h02_00_05_0000_49FF, // R2
    56'h04_02_00_0004_0000, // R4 set error
    56'h04_00_05_0000_41FF, // R4
    56'h04_02_00_000C_0000, // R4 set and clear together
    56'h04_00_05_0000_41FF, // R4 set wins
    56'h04_02_00_0008_0000, // R4 clear error
    56'h04_00_05_0000_49FF, // R4
    56'h09_03_00_BEEF_0000, // R9 local load
    56'h09_00_07_0000_BEEF, // R9
    56'h06_00_02_0000_400C, // R6 status layout
    56'h07_01_02_0003_0000, // R7 write status
    56'h07_00_02_0000_400F, // R7
    56'h07_01_02_FFFC_0000, // R7 upper bits ignored
    56'h07_00_02_0000_400C, // R7
    56'h0B_00_1F_0000_0000, // R11 unmapped read
    56'h0B_01_05_0000_0000, // R11 write to response ignored
    56'h0B_00_05_0000_49FF  // R11
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] kind, input logic [7:0] a, input logic [15:0] d);
    bus_addr = a[4:0];
    bus_wdata = d;
    loc_ctl = d[3:0];
    loc_dat = d;
    bus_rd = (kind == 0);
    bus_wr = (kind == 1);
    loc_ctl_wr = (kind == 2);
    loc_dat_wr = (kind == 3);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; loc_ctl_wr = 0; loc_dat_wr = 0;
  endtask

  task automatic rd_chk(input int req, input logic [7:0] a, input logic [15:0] exp);
    op(8'd0, a, 16'h0);
    chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(10, bus_rdata, 16'h0000);
    chk(10, {15'b0, soft_rst}, 16'h0);
    chk(10, {15'b0, fail_inhibit}, 16'h0);
    chk(10, {15'b0, fail_out}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][47:40], VEC[i][39:32], VEC[i][31:16]);
      if (VEC[i][47:40] == 8'd0) chk(int'(VEC[i][55:48]), bus_rdata, VEC[i][15:0]);
    end

    // R5 set-write-ready collides with bus data write
    bus_addr = 5'd7; bus_wdata = 16'h5555; bus_wr = 1; loc_ctl = 4'h1; loc_ctl_wr = 1;
    @(negedge clk);
    bus_wr = 0; loc_ctl_wr = 0;
    rd_chk(5, 8'h05, 16'h4BFF);
    // R5 set-read-ready collides with bus data read
    bus_addr = 5'd7; bus_rd = 1; loc_ctl = 4'h2; loc_ctl_wr = 1;
    @(negedge clk);
    bus_rd = 0; loc_ctl_wr = 0;
    chk(9, bus_rdata, 16'h5555);
    rd_chk(5, 8'h05, 16'h4FFF);

    // R9 bus write beats local load
    bus_addr = 5'd7; bus_wdata = 16'hAAAA; bus_wr = 1; loc_dat = 16'h1111; loc_dat_wr = 1;
    @(negedge clk);
    bus_wr = 0; loc_dat_wr = 0;
    chk(9, dlow_out, 16'hAAAA);
    rd_chk(9, 8'h07, 16'hAAAA);

    // R6 module-select inverted
    mod_sel = 1;
    rd_chk(6, 8'h02, 16'h000C);
    // R8 failed self-test raises fail_out
    selftest_pass = 0;
    @(negedge clk);
    chk(8, {15'b0, fail_out}, 16'h1);
    rd_chk(6, 8'h02, 16'h0008);
    // R8 inhibit suppresses fail_out
    op(8'd1, 8'h02, 16'h0002);
    chk(8, {15'b0, fail_inhibit}, 16'h1);
    chk(7, {15'b0, soft_rst}, 16'h0);
    @(negedge clk);
    chk(8, {15'b0, fail_out}, 16'h0);
    // R7 enter soft reset, inhibit dropped
    op(8'd1, 8'h02, 16'h0001);
    chk(7, {15'b0, soft_rst}, 16'h1);
    chk(8, {15'b0, fail_inhibit}, 16'h0);
    @(negedge clk);
    chk(8, {15'b0, fail_out}, 16'h1);
    // R7 leave soft reset
    op(8'd1, 8'h02, 16'h0000);
    chk(7, {15'b0, soft_rst}, 16'h0);

    // R10 hard reset mid-run
    op(8'd2, 8'h00, 16'h0007);
    op(8'd1, 8'h02, 16'h0003);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk(10, {15'b0, soft_rst}, 16'h0);
    chk(10, {15'b0, fail_inhibit}, 16'h0);
    rd_chk(10, 8'h05, 16'h49FF);
    rd_chk(10, 8'h02, 16'h0008);

    finish_run();
  end
endmodule